// File: doc/BRIEF.md
# Multi-Channel Carry-Out Pulse-Width Modulator

This block turns digital level words into pulse trains on several output lines, one per channel. It runs at the PWM granularity rate. A single up-counter is shared by every channel. When the counter reaches its all-ones value it raises a sample-enable strobe. On that strobe the counter reloads a programmable start value, and every channel captures a new level word. The counter then climbs back to all-ones, so one period lasts 2^N minus the start value clocks. A preset start value therefore gives resolutions that are not a power of two, for example 100 or 246 levels.

Each channel drives its line from the carry-out of adding the counter to its held level, not from a magnitude comparator. The line therefore goes high in the last `level` cycles of each period. A level of zero keeps the line low for the whole period. A level at or above the period length keeps the line high for the whole period. Upstream logic watches the strobe to know when the next data words are taken.

Top module: `pwm_carry_bank`

## Requirements
- R1: The shared counter steps up by one on every clock edge that has no strobe. `sample_en` is 1 exactly when the counter is all ones. On that edge the counter reloads `start_val`, so with start value S the strobe repeats every 2^CNT_W − S clocks.
- R2: A channel's held level changes only on a strobe edge, where it takes the channel's slice of `data_in` (channel k is bits k*CNT_W to k*CNT_W+CNT_W−1). A change of `data_in` at any other time has no effect on the outputs of the current period.
- R3: During a period started from start value S with held level L, channel output k is high in cycle i of the period (counter value S+i) exactly when S+i+L ≥ 2^CNT_W. It therefore carries min(L, 2^CNT_W − S) high cycles, and they all sit at the end of the period.
- R4: A held level of 0 keeps the channel output low for the whole period.
- R5: A held level of 2^CNT_W − S or more keeps the channel output high for the whole period.
- R6: A change of `start_val` during a period does not shorten or lengthen that period. It is used only at the next strobe.
- R7: A synchronous active-high reset loads the counter with `start_val` and clears all held levels, so every output is low after reset.
- R8: Channels are independent. Each output depends only on the shared counter and its own held level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PWM granularity clock |
| rst | input | 1 | Synchronous active-high reset |
| start_val | input | CNT_W | Counter reload value that sets the period length |
| data_in | input | CHANNELS*CNT_W | Level words, channel k in slice k |
| sample_en | output | 1 | Strobe: the counter is at all ones and data is taken on this edge |
| pwm_out | output | CHANNELS | One pulse-width modulated line per channel |

## Verification
The assertions take two things for granted. First, `start_val` and `data_in` are stable around the rising clock edge. Second, after reset the counter starts at the start value that was applied during reset. The stimulus meets both conditions by driving every input on the falling edge only and by holding the start value while reset is asserted.

Random start values and level words are combined with directed presets of 0, 10, 27, 254 and 255. The directed cases include levels just below, at and above the period length. In every period the stimulus changes both the level words and the start value halfway through. This checks that neither change reaches the outputs or the strobe timing before the next strobe.

// File: rtl/pwm_carry_bank.sv
module pwm_carry_bank #(
  parameter int CNT_W    = 8,
  parameter int CHANNELS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          start_val,
  input  logic [CHANNELS*CNT_W-1:0] data_in,
  output logic                      sample_en,
  output logic [CHANNELS-1:0]       pwm_out
);

  logic [CNT_W-1:0]          cnt;
  logic [CHANNELS*CNT_W-1:0] level;

  assign sample_en = &cnt;

  always_ff @(posedge clk) begin
    if (rst || sample_en) cnt <= start_val;
    else                  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)            level <= '0;
    else if (sample_en) level <= data_in;
  end

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    assign pwm_out[k] = 1'(({1'b0, cnt} + {1'b0, level[k*CNT_W +: CNT_W]}) >> CNT_W);
  end

endmodule

module pwm_carry_bank_chk #(
  parameter int CNT_W    = 8,
  parameter int CHANNELS = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic [CNT_W-1:0]          start_val,
  input logic [CHANNELS*CNT_W-1:0] data_in,
  input logic [CNT_W-1:0]          cnt,
  input logic [CHANNELS*CNT_W-1:0] level,
  input logic                      sample_en,
  input logic [CHANNELS-1:0]       pwm_out
);

  logic             rst_q;
  logic [CNT_W-1:0] sv_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    sv_q  <= start_val;
  end

  always @(negedge clk) begin
    if (rst_q) begin
      assert_reset_state_R7: assert (pwm_out == '0 && cnt == sv_q && level == '0);
    end
  end

  assert_wrap_reload_R1: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> cnt == $past(start_val));

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> cnt == $past(cnt) + 1'b1);

  assert_level_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(level));

  assert_level_load_R2: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> level == $past(data_in));

  for (genvar k = 0; k < CHANNELS; k++) begin : g_chk
    assert_high_until_wrap_R3: assert property (@(posedge clk) disable iff (rst)
      (pwm_out[k] && !sample_en) |=> pwm_out[k]);

    assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
      (level[k*CNT_W +: CNT_W] == '0) |-> !pwm_out[k]);

    assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
      (level[k*CNT_W +: CNT_W] == '1) |-> (pwm_out[k] || cnt == '0));
  end

endmodule

bind pwm_carry_bank pwm_carry_bank_chk #(.CNT_W(CNT_W), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst(rst), .start_val(start_val), .data_in(data_in),
  .cnt(cnt), .level(level), .sample_en(sample_en), .pwm_out(pwm_out)
);

// File: tb/tb_pwm_carry_bank.sv
module tb_pwm_carry_bank;
  localparam int CNT_W    = 8;
  localparam int CHANNELS = 4;
  localparam int FULL     = 1 << CNT_W;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic [CNT_W-1:0]          start_val = '0;
  logic [CHANNELS*CNT_W-1:0] data_in = '0;
  logic                      sample_en;
  logic [CHANNELS-1:0]       pwm_out;

  int n_checks = 0;
  int n_fail   = 0;

  pwm_carry_bank #(.CNT_W(CNT_W), .CHANNELS(CHANNELS)) dut (
    .clk(clk), .rst(rst), .start_val(start_val), .data_in(data_in),
    .sample_en(sample_en), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  function automatic int exp_highs(int s, int lvl);
    int p = FULL - s;
    return (lvl < p) ? lvl : p;
  endfunction

  function automatic bit exp_bit(int s, int i, int lvl);
    return (s + i + lvl) >= FULL;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measure one period starting at the next negedge; caller is at a negedge
  // right after the strobe edge that started it. lv holds the expected levels.
  task automatic measure(int s, int lv[CHANNELS], bit disturb);
    int p = FULL - s;
    int highs[CHANNELS];
    bit posok[CHANNELS];
    bit strobe_ok = 1'b1;
    int strobe_pos = -1;
    for (int k = 0; k < CHANNELS; k++) begin highs[k] = 0; posok[k] = 1'b1; end
    for (int i = 0; i < p; i++) begin
      if (i > 0) @(negedge clk);
      for (int k = 0; k < CHANNELS; k++) begin
        highs[k] += int'(pwm_out[k]);
        if (pwm_out[k] != exp_bit(s, i, lv[k])) posok[k] = 1'b0;
      end
      if (sample_en != (i == p - 1)) strobe_ok = 1'b0;
      if (sample_en && strobe_pos < 0) strobe_pos = i;
      if (disturb && i == p / 2) begin
        data_in   = {$urandom(), $urandom()};
        start_val = CNT_W'($urandom());
      end
    end
    // R1 / R6: strobe exactly at end of the period set at its start
    check(strobe_ok, "R1/R6 period length", strobe_pos + 1, p);
    for (int k = 0; k < CHANNELS; k++) begin
      string tag;
      if (lv[k] == 0)           tag = "R4 zero level";
      else if (lv[k] >= p)      tag = "R5 full level";
      else                      tag = "R3 duty";
      check(highs[k] == exp_highs(s, lv[k]) && posok[k],
            $sformatf("%s ch%0d R8 R2 (S=%0d L=%0d)", tag, k, s, lv[k]),
            highs[k], exp_highs(s, lv[k]));
    end
  endtask

  task automatic run_period(int s, int lv[CHANNELS]);
    start_val = CNT_W'(s);
    for (int k = 0; k < CHANNELS; k++) data_in[k*CNT_W +: CNT_W] = CNT_W'(lv[k]);
    while (sample_en !== 1'b1) @(negedge clk);
    start_val = CNT_W'(s);
    for (int k = 0; k < CHANNELS; k++) data_in[k*CNT_W +: CNT_W] = CNT_W'(lv[k]);
    @(negedge clk);
    measure(s, lv, 1'b1);
  endtask

  initial begin
    int z[CHANNELS];
    int lv[CHANNELS];
    void'($urandom(32'd20240611));
    for (int k = 0; k < CHANNELS; k++) z[k] = 0;

    // R7: reset state, then the first period runs with cleared levels
    repeat (3) @(negedge clk);
    check(pwm_out == '0 && sample_en == 1'b0, "R7 reset outputs",
          int'({pwm_out, sample_en}), 0);
    data_in = {CHANNELS{8'hFF}};
    rst = 1'b0;
    measure(0, z, 1'b0);

    lv = '{0, 1, 128, 255};   run_period(0, lv);
    lv = '{8, 15, 254, 200};  run_period(0, lv);
    lv = '{0, 245, 246, 255}; run_period(10, lv);
    lv = '{1, 100, 228, 229}; run_period(27, lv);
    lv = '{0, 1, 2, 3};       run_period(254, lv);
    lv = '{0, 1, 7, 255};     run_period(255, lv);
    lv = '{5, 0, 230, 114};   run_period(27, lv);

    for (int r = 0; r < 30; r++) begin
      int s = int'($urandom_range(0, 255));
      for (int k = 0; k < CHANNELS; k++) begin
        if ($urandom_range(0, 3) == 0) lv[k] = FULL - s + int'($urandom_range(0, 2)) - 1;
        else                           lv[k] = int'($urandom_range(0, 255));
        if (lv[k] > 255) lv[k] = 255;
        if (lv[k] < 0)   lv[k] = 0;
      end
      run_period(s, lv);
    end

    // R7: reset mid-period clears levels and restarts from start value
    @(negedge clk);
    start_val = 8'd100;
    rst = 1'b1;
    @(negedge clk);
    check(pwm_out == '0, "R7 reset clears outputs", int'(pwm_out), 0);
    data_in = {CHANNELS{8'hFF}};
    rst = 1'b0;
    measure(100, z, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule